// File: doc/BRIEF.md
# Indexed Transfer Register Bank

This block holds the transfer registers between a processing engine and two external memory units: an SRAM group and a DRAM group. Each group has two arrays that share the same register numbers but are separate storage. The engine's own writes go into the outgoing array. Its reads come from the incoming array. The memory side deposits arriving data into the incoming arrays and drains outgoing data from the outgoing arrays before it issues a memory write.

Registers can be named directly with a 7-bit number. They can also be reached indirectly through one shared index register. The same index value selects the register in all four arrays at once. An indirect access can move the index one step up or down afterwards. Any agent may reload the index through its own write port. The block keeps only that single copy.

Top module: `xfer_bank`

## Requirements
- R1: After reset the index is 0, every register in all four arrays holds 0, and both read outputs and both valid flags are 0.
- R2: An engine access with `eng_wr`=1 stores `eng_wdata` into the outgoing array of the group picked by `eng_grp` (0 = SRAM, 1 = DRAM). A drain request returns that register on `drain_data`, with `drain_valid` high, in the cycle after the request.
- R3: A fill writes `fill_data` into the incoming array of `fill_grp`. An engine access with `eng_wr`=0 returns the incoming register on `eng_rdata`, with `eng_rvalid` high, in the cycle after the request.
- R4: An engine write to a register number never changes what an engine read of that number returns. A fill never changes what a drain of that number returns.
- R5: The SRAM and DRAM groups are independent. An access to one group never changes a register of the other group.
- R6: With `eng_ind`=1 the access targets the register numbered by the index, and one index value serves all four arrays.
- R7: `eng_step` applies after an indirect access: 01 adds 1, 10 subtracts 1, and 00 or 11 leaves the index unchanged. The index wraps modulo 128 in both directions. On a direct access (`eng_ind`=0) the step field has no effect.
- R8: A load with `idx_we` takes effect for accesses in the following cycle. An indirect access in the same cycle uses the old index. A load wins over a step requested in the same cycle.
- R9: A fill and an engine write to the same register number in the same cycle both complete, because they target different arrays.
- R10: When a register is read and written in the same cycle, the read returns the value held before that cycle. This applies to an engine read against a fill, and to a drain against an engine write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_en | input | 1 | Engine access request |
| eng_wr | input | 1 | 1 = write outgoing array, 0 = read incoming array |
| eng_grp | input | 1 | Group: 0 SRAM, 1 DRAM |
| eng_ind | input | 1 | 1 = address from index register |
| eng_addr | input | 7 | Direct register number |
| eng_step | input | 2 | Index step after an indirect access |
| eng_wdata | input | 32 | Engine write data |
| eng_rdata | output | 32 | Engine read data, one cycle after request |
| eng_rvalid | output | 1 | Engine read data valid |
| fill_en | input | 1 | Memory-side fill request |
| fill_grp | input | 1 | Fill group |
| fill_addr | input | 7 | Fill register number |
| fill_data | input | 32 | Fill data |
| drain_en | input | 1 | Memory-side drain request |
| drain_grp | input | 1 | Drain group |
| drain_addr | input | 7 | Drain register number |
| drain_data | output | 32 | Drain data, one cycle after request |
| drain_valid | output | 1 | Drain data valid |
| idx_we | input | 1 | Index register load |
| idx_wdata | input | 7 | Index load value |

## Verification
The assertions assume that all control inputs are known (0 or 1) in every cycle after reset. They also assume that `eng_step` only matters when `eng_en` and `eng_ind` are both high. The stimulus changes inputs only on the falling clock edge and clears every request once its cycle is over, so no stray request reaches the design. It combines loads, steps, fills, writes and drains in the same cycle on purpose, because the ordering rules hold there. A random phase keeps every field inside its declared width, and register numbers therefore stay within 0..127.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   typedef enum logic [1:0] {
      STEP_NONE = 2'b00,
      STEP_INC  = 2'b01,
      STEP_DEC  = 2'b10,
      STEP_KEEP = 2'b11
   } step_e;

   localparam int unsigned NUM_GRP = 2;   // 0 = SRAM group, 1 = DRAM group
endpackage

// File: rtl/xfer_index.sv
module xfer_index
   import xfer_pkg::*;
#(
   parameter int unsigned IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_val,
   input  logic             step_en,
   input  step_e            step,
   output logic [IDX_W-1:0] idx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (ld_en) begin
         idx_q <= ld_val;
      end else if (step_en) begin
         unique case (step)
            STEP_INC: idx_q <= idx_q + 1'b1;
            STEP_DEC: idx_q <= idx_q - 1'b1;
            default:  idx_q <= idx_q;
         endcase
      end
   end

   // R8: a load is visible in the next cycle and overrides any step
   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> idx_q == $past(ld_val));
   // R7: increment wraps modulo depth
   a_r7_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && step_en && step == STEP_INC) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
   // R7: decrement wraps modulo depth
   a_r7_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && step_en && step == STEP_DEC) |=> idx_q == IDX_W'($past(idx_q) - 1'b1));
   // R7: no request means the index holds
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && (!step_en || step == STEP_NONE || step == STEP_KEEP)) |=> $stable(idx_q));
endmodule

// File: rtl/xfer_array.sv
module xfer_array #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DEPTH    = 128,
   parameter bit          CLR_DATA = 1'b1,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLR_DATA) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

   // R2/R3: a write lands in the addressed entry
   a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));
   // R10: a read returns the contents before any same-cycle write
   a_r10_read_old: assert property (@(posedge clk) disable iff (!rst_n)
      re |=> rdata == $past(mem[raddr]));
endmodule

// File: rtl/xfer_bank.sv
module xfer_bank
   import xfer_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DEPTH    = 128,
   parameter bit          CLR_DATA = 1'b1,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_en,
   input  logic              eng_wr,
   input  logic              eng_grp,
   input  logic              eng_ind,
   input  logic [AW-1:0]     eng_addr,
   input  logic [1:0]        eng_step,
   input  logic [DATA_W-1:0] eng_wdata,
   output logic [DATA_W-1:0] eng_rdata,
   output logic              eng_rvalid,
   input  logic              fill_en,
   input  logic              fill_grp,
   input  logic [AW-1:0]     fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              drain_en,
   input  logic              drain_grp,
   input  logic [AW-1:0]     drain_addr,
   output logic [DATA_W-1:0] drain_data,
   output logic              drain_valid,
   input  logic              idx_we,
   input  logic [AW-1:0]     idx_wdata
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 || DATA_W < 1) begin : g_bad_cfg
         $error("xfer_bank: DEPTH must be a power of two >= 2 and DATA_W >= 1");
      end
   endgenerate

   logic [AW-1:0]     idx_q;
   logic [AW-1:0]     eng_sel;
   logic              eng_rd, eng_wt;
   logic [DATA_W-1:0] in_rdata  [NUM_GRP];
   logic [DATA_W-1:0] out_rdata [NUM_GRP];
   logic              eng_grp_q, drain_grp_q;

   assign eng_sel = eng_ind ? idx_q : eng_addr;
   assign eng_rd  = eng_en && !eng_wr;
   assign eng_wt  = eng_en &&  eng_wr;

   xfer_index #(.IDX_W(AW)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (idx_we),
      .ld_val  (idx_wdata),
      .step_en (eng_en && eng_ind),
      .step    (step_e'(eng_step)),
      .idx_q   (idx_q)
   );

   for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_grp
      // incoming array: filled by memory, read by engine
      xfer_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLR_DATA(CLR_DATA)) u_in (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (fill_en && (fill_grp == 1'(g))),
         .waddr (fill_addr),
         .wdata (fill_data),
         .re    (eng_rd && (eng_grp == 1'(g))),
         .raddr (eng_sel),
         .rdata (in_rdata[g])
      );
      // outgoing array: written by engine, drained by memory
      xfer_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLR_DATA(CLR_DATA)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (eng_wt && (eng_grp == 1'(g))),
         .waddr (eng_sel),
         .wdata (eng_wdata),
         .re    (drain_en && (drain_grp == 1'(g))),
         .raddr (drain_addr),
         .rdata (out_rdata[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_rvalid  <= 1'b0;
         drain_valid <= 1'b0;
         eng_grp_q   <= 1'b0;
         drain_grp_q <= 1'b0;
      end else begin
         eng_rvalid  <= eng_rd;
         drain_valid <= drain_en;
         if (eng_rd)   eng_grp_q   <= eng_grp;
         if (drain_en) drain_grp_q <= drain_grp;
      end
   end

   assign eng_rdata  = in_rdata[eng_grp_q];
   assign drain_data = out_rdata[drain_grp_q];

   // R3: every engine read yields data one cycle later
   a_r3_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rd |=> eng_rvalid);
   // R2: every drain yields data one cycle later
   a_r2_dvalid: assert property (@(posedge clk) disable iff (!rst_n)
      drain_en |=> drain_valid);
   // R7: a direct access leaves the index alone
   a_r7_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && !eng_ind && !idx_we) |=> $stable(idx_q));
   // R4: an engine write leaves the engine-visible data of its group unchanged
   a_r4_isolate: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_wt && !fill_en && !eng_rd) |=> $stable(in_rdata[0]) && $stable(in_rdata[1]));
endmodule

// File: tb/xfer_bank_bench.sv
`timescale 1ns/1ps
module xfer_bank_bench;
   localparam int DW = 32;
   localparam int D  = 128;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          eng_en = 0, eng_wr = 0, eng_grp = 0, eng_ind = 0;
   logic [AW-1:0] eng_addr = '0;
   logic [1:0]    eng_step = '0;
   logic [DW-1:0] eng_wdata = '0;
   logic [DW-1:0] eng_rdata;
   logic          eng_rvalid;
   logic          fill_en = 0, fill_grp = 0;
   logic [AW-1:0] fill_addr = '0;
   logic [DW-1:0] fill_data = '0;
   logic          drain_en = 0, drain_grp = 0;
   logic [AW-1:0] drain_addr = '0;
   logic [DW-1:0] drain_data;
   logic          drain_valid;
   logic          idx_we = 0;
   logic [AW-1:0] idx_wdata = '0;

   int errors = 0;
   int checks = 0;

   logic [DW-1:0] m_in  [2][D];
   logic [DW-1:0] m_out [2][D];
   logic [AW-1:0] m_idx;

   logic [DW-1:0] eq_d[$];
   string         eq_t[$];
   logic [DW-1:0] dq_d[$];
   string         dq_t[$];

   always #4 clk = ~clk;

   xfer_bank u_xfer_bank (
      .clk(clk), .rst_n(rst_n),
      .eng_en(eng_en), .eng_wr(eng_wr), .eng_grp(eng_grp), .eng_ind(eng_ind),
      .eng_addr(eng_addr), .eng_step(eng_step), .eng_wdata(eng_wdata),
      .eng_rdata(eng_rdata), .eng_rvalid(eng_rvalid),
      .fill_en(fill_en), .fill_grp(fill_grp), .fill_addr(fill_addr), .fill_data(fill_data),
      .drain_en(drain_en), .drain_grp(drain_grp), .drain_addr(drain_addr),
      .drain_data(drain_data), .drain_valid(drain_valid),
      .idx_we(idx_we), .idx_wdata(idx_wdata)
   );

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expectations as results appear
   always @(negedge clk) begin
      if (rst_n && eng_rvalid) begin
         if (eq_d.size() == 0) check("R3 unexpected eng_rvalid", 32'h1, 32'h0);
         else check(eq_t.pop_front(), eng_rdata, eq_d.pop_front());
      end
      if (rst_n && drain_valid) begin
         if (dq_d.size() == 0) check("R2 unexpected drain_valid", 32'h1, 32'h0);
         else check(dq_t.pop_front(), drain_data, dq_d.pop_front());
      end
   end

   // driver: inputs already set; predict, update model, advance one cycle
   task automatic tick(string tag);
      logic [AW-1:0] sel;
      sel = eng_ind ? m_idx : eng_addr;
      if (eng_en && !eng_wr) begin
         eq_d.push_back(m_in[eng_grp][sel]);
         eq_t.push_back({tag, " eng read"});
      end
      if (drain_en) begin
         dq_d.push_back(m_out[drain_grp][drain_addr]);
         dq_t.push_back({tag, " drain"});
      end
      if (eng_en && eng_wr) m_out[eng_grp][sel] = eng_wdata;
      if (fill_en) m_in[fill_grp][fill_addr] = fill_data;
      if (idx_we) m_idx = idx_wdata;
      else if (eng_en && eng_ind) begin
         if (eng_step == 2'b01) m_idx = m_idx + 1'b1;
         else if (eng_step == 2'b10) m_idx = m_idx - 1'b1;
      end
      @(negedge clk);
      eng_en = 0; eng_wr = 0; eng_ind = 0; eng_step = 0;
      fill_en = 0; drain_en = 0; idx_we = 0;
   endtask

   task automatic eng(bit wr, bit grp, bit ind, logic [AW-1:0] a, logic [1:0] st, logic [DW-1:0] wd);
      eng_en = 1; eng_wr = wr; eng_grp = grp; eng_ind = ind;
      eng_addr = a; eng_step = st; eng_wdata = wd;
   endtask
   task automatic fill(bit grp, logic [AW-1:0] a, logic [DW-1:0] d);
      fill_en = 1; fill_grp = grp; fill_addr = a; fill_data = d;
   endtask
   task automatic drain(bit grp, logic [AW-1:0] a);
      drain_en = 1; drain_grp = grp; drain_addr = a;
   endtask
   task automatic ldidx(logic [AW-1:0] v);
      idx_we = 1; idx_wdata = v;
   endtask

   initial begin
      #(8 * 200000);
      check("watchdog expired", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int g = 0; g < 2; g++)
         for (int i = 0; i < D; i++) begin m_in[g][i] = '0; m_out[g][i] = '0; end
      m_idx = '0;
      repeat (3) @(negedge clk);
      // R1: outputs idle in reset
      check("R1 eng_rdata", eng_rdata, '0);
      check("R1 eng_rvalid", {31'b0, eng_rvalid}, '0);
      check("R1 drain_valid", {31'b0, drain_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: all storage cleared, index at 0
      eng(0, 0, 0, 7'd5, 0, 0); drain(1, 7'd127); tick("R1");
      eng(0, 1, 0, 7'd127, 0, 0); drain(0, 7'd0); tick("R1");
      fill(0, 7'd0, 32'h0BAD_0000); tick("R1 fill");
      eng(0, 0, 1, 7'd99, 0, 0); tick("R1 index zero");
      // R3/R5: fills in both groups, read back
      fill(0, 7'd3, 32'hAAAA_0003); tick("R3");
      fill(1, 7'd3, 32'hBBBB_0003); tick("R3");
      eng(0, 0, 0, 7'd3, 0, 0); tick("R3 sram");
      eng(0, 1, 0, 7'd3, 0, 0); tick("R5 dram");
      // R2/R4/R5: engine write to same name
      eng(1, 0, 0, 7'd3, 0, 32'hCCCC_0003); tick("R2");
      eng(0, 0, 0, 7'd3, 0, 0); tick("R4 read unaffected by write");
      drain(0, 7'd3); tick("R2 drain");
      drain(1, 7'd3); tick("R5 other group untouched");
      // R8: load with same-cycle stepping indirect read
      fill(0, 7'd9, 32'h9999_0009); tick("R8");
      fill(0, 7'd10, 32'h1010_000A); tick("R8");
      fill(0, 7'd11, 32'h1111_000B); tick("R8");
      ldidx(7'd10); eng(0, 0, 1, 0, 2'b01, 0); tick("R8 old index used");
      eng(0, 0, 1, 0, 2'b01, 0); tick("R8 load wins over step");
      eng(0, 0, 1, 0, 2'b10, 0); tick("R7 after inc");
      eng(0, 0, 1, 0, 2'b10, 0); tick("R7 after dec");
      eng(0, 0, 1, 0, 2'b11, 0); tick("R7 dec result");
      eng(0, 0, 1, 0, 2'b00, 0); tick("R7 step 11 holds");
      // R7: wrap upward
      ldidx(7'd127); tick("R7 load");
      eng(1, 1, 1, 0, 2'b01, 32'hD127_D127); tick("R7");
      eng(1, 1, 1, 0, 2'b01, 32'hD000_D000); tick("R7");
      drain(1, 7'd127); tick("R7 wr at 127");
      drain(1, 7'd0); tick("R7 wrap to 0");
      // R7: wrap downward
      fill(1, 7'd127, 32'hF127_F127); ldidx(7'd0); tick("R7");
      eng(0, 1, 1, 0, 2'b10, 0); tick("R7 read at 0");
      eng(0, 1, 1, 0, 2'b00, 0); tick("R7 wrap to 127");
      // R7: direct access ignores step
      ldidx(7'd20); fill(0, 7'd20, 32'h2020_2020); tick("R7");
      eng(0, 0, 0, 7'd3, 2'b01, 0); tick("R7 direct");
      eng(0, 0, 0, 7'd4, 2'b10, 0); tick("R7 direct");
      eng(0, 0, 1, 0, 2'b00, 0); tick("R7 index unchanged by direct");
      // R9: fill and engine write to same number in one cycle
      ldidx(7'd40); tick("R9");
      fill(0, 7'd40, 32'hE040_E040); eng(1, 0, 1, 0, 2'b00, 32'hF040_F040); tick("R9");
      eng(0, 0, 0, 7'd40, 0, 0); tick("R9 fill kept");
      drain(0, 7'd40); tick("R9 write kept");
      // R10: read vs write same cycle
      fill(0, 7'd50, 32'h6050_6050); eng(0, 0, 0, 7'd50, 0, 0); tick("R10 read old");
      eng(0, 0, 0, 7'd50, 0, 0); tick("R10 then new");
      eng(1, 1, 0, 7'd60, 0, 32'h7060_7060); drain(1, 7'd60); tick("R10 drain old");
      drain(1, 7'd60); tick("R10 then new");
      // R6: one index value serves all four arrays
      ldidx(7'd30); fill(0, 7'd30, 32'h5A30_0000); tick("R6");
      fill(1, 7'd30, 32'h5B30_0001); eng(1, 0, 1, 0, 0, 32'h3A30_0002); tick("R6");
      eng(1, 1, 1, 0, 0, 32'h3B30_0003); tick("R6");
      eng(0, 0, 1, 0, 0, 0); drain(0, 7'd30); tick("R6 sram");
      eng(0, 1, 1, 0, 0, 0); drain(1, 7'd30); tick("R6 dram");
      // mixed random traffic against the model
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(1)) eng($urandom_range(1), $urandom_range(1), $urandom_range(1),
                                   7'($urandom), 2'($urandom), $urandom);
         if ($urandom_range(1)) fill($urandom_range(1), 7'($urandom), $urandom);
         if ($urandom_range(1)) drain($urandom_range(1), 7'($urandom));
         if ($urandom_range(7) == 0) ldidx(7'($urandom));
         tick("R4 R5 R7 mixed");
      end
      repeat (3) @(negedge clk);
      check("R3 pending reads", 32'(eq_d.size()), 32'h0);
      check("R2 pending drains", 32'(dq_d.size()), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule